// File: doc/BRIEF.md
# Interrupt Status Aggregator

This block collects the interrupt causes of a streaming audio controller into a single 32-bit read-only status word and one level interrupt request. Each of four input streams and four output streams supplies a small vector of status flags. The controller supplies three event flags: response received, response buffer overrun, and serial data input state change.

Aggregation happens in two levels. Each stream's flags are ORed into one stream bit, and the three controller events are ORed into a controller bit. A global bit then summarises everything below it. The status word shows every cause whether or not it is enabled. The interrupt line is masked by per-stream enables, a controller enable and a global enable, and it is registered. A read port returns the word at offset 24h.

Top module: `irq_status_agg`

## Requirements
- R1: While `rst` is high, `stat_word` and `rd_data` read zero. The cycle after a clock edge with `rst` high, `irq` is low.
- R2: `stat_word` bit i, for i from 0 to 3, is the OR of the flags of input stream i+1. Bit 4+i is the OR of the flags of output stream i+1. The flags of stream k (zero-based) sit in bits [k*SF +: SF] of `in_flags` or `out_flags`.
- R3: `stat_word` bit 30 is the OR of `ctrl_evt[2:0]`, where bit 0 is response received, bit 1 is response buffer overrun and bit 2 is serial input state change.
- R4: `stat_word` bit 31 is the OR of bits 30:0. Bits 29:8 always read zero.
- R5: Status bits follow their sources combinationally in the same cycle, whatever the values of `stream_ie`, `ctrl_ie` and `glob_ie`.
- R6: `irq` equals, one clock edge later, `glob_ie & (|(stat_word[7:0] & stream_ie) | (stat_word[30] & ctrl_ie))`.
- R7: With `glob_ie` low at a clock edge, `irq` is low after that edge.
- R8: `pwr_wake`, which marks a low-power to active transition, has no effect on `stat_word`, `rd_data` or `irq`.
- R9: `rd_data` equals `stat_word` when `reg_addr` is 8'h24, and zero for any other value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high controller reset |
| pwr_wake | input | 1 | Low-power to active transition marker |
| in_flags | input | 4*SF | Input stream status flags |
| out_flags | input | 4*SF | Output stream status flags |
| ctrl_evt | input | 3 | Controller event flags |
| stream_ie | input | 8 | Per-stream interrupt enables |
| ctrl_ie | input | 1 | Controller interrupt enable |
| glob_ie | input | 1 | Global interrupt enable |
| reg_addr | input | 8 | Register select offset |
| rd_data | output | 32 | Read data |
| stat_word | output | 32 | Assembled status word |
| irq | output | 1 | Registered level interrupt |

## Verification
The assertions assume that inputs change only between clock edges, and that a power-transition pulse comes with source flags that are held steady. That is why the wake check compares the word only when the sources are stable across the edge. The bench drives every input on the falling edge and holds the flags constant around each wake pulse. It releases reset only on a falling edge, so no property samples a half-updated input.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int NUM_IN      = 4;
    localparam int NUM_OUT     = 4;
    localparam int NUM_STREAMS = NUM_IN + NUM_OUT;
    localparam int NUM_CTRL    = 3;
    localparam int WORD_W      = 32;
    localparam int RSVD_W      = WORD_W - 2 - NUM_STREAMS;
    localparam logic [7:0] STAT_OFFSET = 8'h24;

    typedef struct packed {
        logic                    glob;
        logic                    ctrl;
        logic [RSVD_W-1:0]       rsvd;
        logic [NUM_STREAMS-1:0]  strm;
    } stat_word_t;

    typedef struct packed {
        logic resp;
        logic ovrn;
        logic sdchg;
    } ctrl_evt_t;

    function automatic stat_word_t build_word(logic [NUM_STREAMS-1:0] s, logic c);
        stat_word_t w;
        w.strm = s;
        w.ctrl = c;
        w.rsvd = '0;
        w.glob = c | (|s);
        return w;
    endfunction
endpackage

// File: rtl/irq_agg_stream_or.sv
module irq_agg_stream_or #(
    parameter int SF = 3
) (
    input  logic [SF-1:0] flags,
    output logic          any
);
    assign any = |flags;
endmodule

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
    import irq_agg_pkg::*;
(
    input  logic [NUM_CTRL-1:0] evt,
    output logic                cis
);
    ctrl_evt_t e;
    always_comb begin
        e.sdchg = evt[2];
        e.ovrn  = evt[1];
        e.resp  = evt[0];
        cis = e.resp | e.ovrn | e.sdchg;
    end
endmodule

// File: rtl/irq_agg_irq.sv
module irq_agg_irq
    import irq_agg_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_STREAMS-1:0] strm,
    input  logic                   cis,
    input  logic [NUM_STREAMS-1:0] stream_ie,
    input  logic                   ctrl_ie,
    input  logic                   glob_ie,
    output logic                   irq
);
    logic req_d;
    always_comb req_d = glob_ie & ((|(strm & stream_ie)) | (cis & ctrl_ie));

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= req_d;
    end

    assert_global_mask_R7: assert property (@(posedge clk) disable iff (rst)
        !glob_ie |=> !irq);
    assert_irq_has_cause_R6: assert property (@(posedge clk) disable iff (rst)
        !(|strm) && !cis |=> !irq);
endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
    import irq_agg_pkg::*;
#(
    parameter int SF = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   pwr_wake,
    input  logic [NUM_IN*SF-1:0]   in_flags,
    input  logic [NUM_OUT*SF-1:0]  out_flags,
    input  logic [NUM_CTRL-1:0]    ctrl_evt,
    input  logic [NUM_STREAMS-1:0] stream_ie,
    input  logic                   ctrl_ie,
    input  logic                   glob_ie,
    input  logic [7:0]             reg_addr,
    output logic [WORD_W-1:0]      rd_data,
    output logic [WORD_W-1:0]      stat_word,
    output logic                   irq
);
    localparam int ALL_W = NUM_STREAMS * SF;

    logic [ALL_W-1:0]       all_flags;
    logic [NUM_STREAMS-1:0] strm_any;
    logic                   cis_raw;
    stat_word_t             word;

    // Input streams take the low bits, output streams follow.
    assign all_flags = {out_flags, in_flags};

    for (genvar k = 0; k < NUM_STREAMS; k++) begin : g_strm
        irq_agg_stream_or #(.SF(SF)) u_or (
            .flags (all_flags[k*SF +: SF]),
            .any   (strm_any[k])
        );
    end

    irq_agg_ctrl u_ctrl (
        .evt (ctrl_evt),
        .cis (cis_raw)
    );

    always_comb begin
        if (rst) word = '0;
        else     word = build_word(strm_any, cis_raw);
    end

    assign stat_word = word;
    assign rd_data   = (reg_addr == STAT_OFFSET) ? word : '0;

    irq_agg_irq u_irq (
        .clk       (clk),
        .rst       (rst),
        .strm      (word.strm),
        .cis       (word.ctrl),
        .stream_ie (stream_ie),
        .ctrl_ie   (ctrl_ie),
        .glob_ie   (glob_ie),
        .irq       (irq)
    );

    always_comb begin
        assert_glob_summary_R4: assert (stat_word[31] == (|stat_word[30:0]));
        assert_read_decode_R9: assert ((reg_addr == STAT_OFFSET) || (rd_data == '0));
    end

    assert_reset_quiet_R1: assert property (@(posedge clk) rst |=> !irq);
    assert_wake_keeps_R8: assert property (@(posedge clk) disable iff (rst)
        (pwr_wake && !$past(rst) && $stable(in_flags) && $stable(out_flags) && $stable(ctrl_evt))
        |-> (stat_word == $past(stat_word)));
endmodule

// File: tb/irq_status_agg_tb.sv
module irq_status_agg_tb;
    localparam int SF = 3;

    logic          clk = 1'b0;
    logic          rst;
    logic          pwr_wake;
    logic [4*SF-1:0] in_flags, out_flags;
    logic [2:0]    ctrl_evt;
    logic [7:0]    stream_ie;
    logic          ctrl_ie, glob_ie;
    logic [7:0]    reg_addr;
    logic [31:0]   rd_data, stat_word;
    logic          irq;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    irq_status_agg #(.SF(SF)) u_dut (
        .clk(clk), .rst(rst), .pwr_wake(pwr_wake),
        .in_flags(in_flags), .out_flags(out_flags), .ctrl_evt(ctrl_evt),
        .stream_ie(stream_ie), .ctrl_ie(ctrl_ie), .glob_ie(glob_ie),
        .reg_addr(reg_addr), .rd_data(rd_data), .stat_word(stat_word), .irq(irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_word();
        logic [31:0] w = '0;
        for (int s = 0; s < 4; s++) begin
            for (int f = 0; f < SF; f++) begin
                if (in_flags[s*SF+f])  w[s]   = 1'b1;
                if (out_flags[s*SF+f]) w[4+s] = 1'b1;
            end
        end
        w[30] = ctrl_evt[0] | ctrl_evt[1] | ctrl_evt[2];
        w[31] = (w[7:0] != 0) || w[30];
        return w;
    endfunction

    function automatic logic model_irq();
        logic [31:0] w = model_word();
        return glob_ie && (((w[7:0] & stream_ie) != 0) || (w[30] && ctrl_ie));
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_src();
        in_flags = '0; out_flags = '0; ctrl_evt = '0;
    endtask

    task automatic t_reset();
        in_flags = '1; out_flags = '1; ctrl_evt = '1;
        stream_ie = '1; ctrl_ie = 1; glob_ie = 1; reg_addr = 8'h24;
        rst = 1; #1;
        check("R1 word in reset", stat_word, 0);
        check("R1 rd_data in reset", rd_data, 0);
        step();
        check("R1 irq after reset edge", {31'b0, irq}, 0);
        clear_src();
        rst = 0;
        step();
    endtask

    task automatic t_stream_map();
        stream_ie = '0; ctrl_ie = 0; glob_ie = 0;
        for (int s = 0; s < 4; s++) begin
            for (int f = 0; f < SF; f++) begin
                clear_src();
                in_flags[s*SF+f] = 1'b1; #1;
                check("R2 input stream bit", stat_word, (32'h1 << s) | 32'h8000_0000);
                clear_src();
                out_flags[s*SF+f] = 1'b1; #1;
                check("R2 output stream bit", stat_word, (32'h10 << s) | 32'h8000_0000);
            end
        end
        clear_src();
        in_flags = 12'b101_000_011_000; out_flags = 12'b000_111_000_001; #1;
        check("R2 mixed pattern", stat_word, model_word());
        clear_src(); #1;
        check("R4 all clear", stat_word, 0);
    endtask

    task automatic t_ctrl();
        for (int e = 0; e < 3; e++) begin
            clear_src();
            ctrl_evt[e] = 1'b1; #1;
            check("R3 controller event", stat_word, 32'hC000_0000);
        end
        clear_src();
        in_flags = '1; out_flags = '1; ctrl_evt = '1; #1;
        check("R4 reserved zero with all set", stat_word & 32'h3FFF_FF00, 0);
        check("R4 global bit", stat_word, 32'hC000_00FF);
        clear_src();
    endtask

    task automatic t_unmasked_and_irq();
        stream_ie = '0; ctrl_ie = 0; glob_ie = 1;
        clear_src();
        out_flags[2*SF] = 1'b1; ctrl_evt = 3'b010; #1;
        check("R5 status visible with enables off", stat_word, 32'hC000_0040);
        step();
        check("R5 irq stays low when unenabled", {31'b0, irq}, 0);
        stream_ie = 8'h40; #1;
        check("R6 irq not yet high before edge", {31'b0, irq}, 0);
        step();
        check("R6 irq after stream enable", {31'b0, irq}, {31'b0, model_irq()});
        stream_ie = 8'hBF; step();
        check("R6 other stream enables do not fire", {31'b0, irq}, 0);
        stream_ie = 0; ctrl_ie = 1; step();
        check("R6 controller enable fires", {31'b0, irq}, 1);
        glob_ie = 0; step();
        check("R7 global enable masks", {31'b0, irq}, 0);
        check("R7 status unchanged under mask", stat_word, 32'hC000_0040);
        glob_ie = 1; ctrl_evt = 0; step();
        check("R6 controller cause removed", {31'b0, irq}, 0);
        clear_src(); step();
    endtask

    task automatic t_wake();
        stream_ie = '1; ctrl_ie = 1; glob_ie = 1; reg_addr = 8'h24;
        clear_src();
        in_flags[SF] = 1'b1; ctrl_evt = 3'b100; step();
        pwr_wake = 1; #1;
        check("R8 word kept on wake", stat_word, 32'hC000_0002);
        step();
        check("R8 irq kept on wake", {31'b0, irq}, 1);
        check("R8 read kept on wake", rd_data, 32'hC000_0002);
        pwr_wake = 0; step();
        check("R8 irq after wake", {31'b0, irq}, 1);
        rst = 1; #1;
        check("R1 reset clears live status", stat_word, 0);
        step(); rst = 0; clear_src(); step();
        check("R1 irq low after reset", {31'b0, irq}, 0);
    endtask

    task automatic t_read();
        clear_src();
        out_flags[3*SF+1] = 1'b1; ctrl_evt = 3'b001;
        reg_addr = 8'h24; #1;
        check("R9 read at 24h", rd_data, 32'hC000_0080);
        reg_addr = 8'h20; #1;
        check("R9 read at 20h", rd_data, 0);
        reg_addr = 8'h30; #1;
        check("R9 read at 30h", rd_data, 0);
        reg_addr = 8'h25; #1;
        check("R9 read at 25h", rd_data, 0);
        clear_src();
    endtask

    initial begin
        pwr_wake = 0; rst = 1; reg_addr = 0;
        clear_src(); stream_ie = 0; ctrl_ie = 0; glob_ie = 0;
        @(negedge clk);
        t_reset();
        t_stream_map();
        t_ctrl();
        t_unmasked_and_irq();
        t_wake();
        t_read();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #2_000_000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule